// File: doc/BRIEF.md
# Shadowed Ramp Reference Generator

This block produces a 16-bit sawtooth reference and turns it into a 12-bit value for a DAC. Each period begins on a start event. After a start the block waits a programmable number of system cycles, then moves the value by a programmable step once per divided clock period, either up or down. Stepping stops at 0 or at 0xFFFF; the value never wraps. A comparator trip reloads the value, from either the active or the shadow reference, and stepping stops until the next start.

Software writes the reference, step, delay and divider into shadow inputs. Each accepted start copies them into active registers, so a running period is not affected by later shadow writes. The DAC value can come from the upper bits of the ramp or from a static software value. That static value is copied either on every clock or only on the sync pulse. Start-of-ramp and end-of-ramp strobes let two of these generators be chained, with one side starting on the other's trip. A suspend input can freeze the ramp, park it at the next start, or be ignored.

Top module: `ramp_ref_gen`

## Requirements
- R1: While `rst` is high, every output is driven to zero on each clock edge, whatever the other inputs do.
- R2: An accepted start copies the shadow reference, step, delay and divider into the active outputs and loads `ramp_o` with the shadow reference at the same edge. `sor_o` is high for the one following cycle. Later shadow changes leave the active values alone.
- R3: With delay D and divider V, the value after the k-th edge following a start has moved by n steps: n = 0 for k <= D, and n = floor((k-D)/(V+1)) otherwise.
- R4: `dir_up_i` = 1 adds the active step at each step time. `dir_up_i` = 0 subtracts it.
- R5: An increment that would pass 0xFFFF gives 0xFFFF. A decrement that would go below 0 gives 0.
- R6: A trip with no start in the same cycle reloads `ramp_o` from the active reference when `trip_from_shd_i` = 0, or from the shadow reference when it is 1. `eor_o` is high the next cycle, and the value then holds until the next start.
- R7: When a start and a trip arrive in the same cycle, the start wins: the value loads the shadow reference, `sor_o` rises and `eor_o` stays low.
- R8: `xtrig_i` selects the start source. On the low-side instance (`LOW_SIDE`=1), 2'b01 starts on `peer_eor_i` and ignores `sync_i`. The codes 2'b00, 2'b10 and 2'b11 start on `sync_i` and ignore `peer_eor_i`. On the high-side instance, the code 2'b10 plays the role that 2'b01 plays on the low side.
- R9: With `suspend_i` = 1 and `susp_mode_i` = 2'b00, the value, the counters and the active registers hold, and starts and trips are ignored. Once released, stepping continues from where it stopped.
- R10: With `suspend_i` = 1 and `susp_mode_i` = 2'b01, the ramp keeps stepping until the next start event. That event is refused and the value is parked. It stays parked until `suspend_i` falls and a new start arrives.
- R11: With `susp_mode_i[1]` = 1, suspend has no effect.
- R12: With `dac_from_ramp_i` = 1, `dac_o` equals bits 15..4 of the `ramp_o` value from one cycle earlier.
- R13: With `dac_from_ramp_i` = 0, `dac_o` takes `shd_dac_i` at every edge when `dac_on_sync_i` = 0, and only at edges where `sync_i` is high when `dac_on_sync_i` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| sync_i | input | 1 | Periodic sync pulse of this generator |
| peer_eor_i | input | 1 | End-of-ramp strobe from the twin generator |
| trip_i | input | 1 | Comparator trip event |
| suspend_i | input | 1 | Debug suspend request |
| susp_mode_i | input | 2 | Suspend handling: 00 freeze, 01 park at next start, 1x ignore |
| xtrig_i | input | 2 | Cross-trigger mode |
| dir_up_i | input | 1 | 1 increments, 0 decrements |
| trip_from_shd_i | input | 1 | Trip reload source: 0 active, 1 shadow reference |
| dac_from_ramp_i | input | 1 | DAC source: 1 ramp, 0 static shadow value |
| dac_on_sync_i | input | 1 | Static DAC copy: 0 every clock, 1 on sync only |
| shd_ref_i | input | 16 | Shadow reference |
| shd_step_i | input | 16 | Shadow step |
| shd_delay_i | input | 13 | Shadow start delay in system cycles |
| shd_div_i | input | 4 | Shadow step clock divider |
| shd_dac_i | input | 12 | Static shadow DAC value |
| ramp_o | output | 16 | Present ramp value |
| dac_o | output | 12 | Active DAC value |
| sor_o | output | 1 | Start-of-ramp strobe |
| eor_o | output | 1 | End-of-ramp strobe |
| act_ref_o | output | 16 | Active reference |
| act_step_o | output | 16 | Active step |
| act_delay_o | output | 13 | Active delay |
| act_div_o | output | 4 | Active divider |

## Verification
The monotonic-value properties assume that the direction input is honoured only when neither a start nor a trip reload is taken. For that reason they are guarded by those internal events and not by the raw pins. The stimulus keeps trip, sync and peer strobes to single-cycle pulses applied between clock edges. It changes the direction or the suspend mode only between periods or at chosen points in a period, so the expected value can always be computed in closed form from the step count. Random periods draw the delay and divider from small ranges and the step from the full range, so saturation at both ends is reached often.

// File: rtl/ramp_ref_pkg.sv
package ramp_ref_pkg;
  typedef enum logic [1:0] {
    XT_OWN          = 2'b00,
    XT_LOW_FOLLOWS  = 2'b01,
    XT_HIGH_FOLLOWS = 2'b10,
    XT_RSVD         = 2'b11
  } xtrig_e;

  typedef enum logic [1:0] {
    SUSP_HARD    = 2'b00,
    SUSP_AT_SYNC = 2'b01,
    SUSP_FREE_A  = 2'b10,
    SUSP_FREE_B  = 2'b11
  } susp_e;

  typedef enum logic {
    RS_IDLE = 1'b0,
    RS_RUN  = 1'b1
  } rstate_e;
endpackage

// File: rtl/ramp_start_ctrl.sv
module ramp_start_ctrl
  import ramp_ref_pkg::*;
#(
  parameter bit LOW_SIDE = 1'b1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       sync_i,
  input  logic       peer_eor_i,
  input  logic       trip_i,
  input  logic       suspend_i,
  input  logic [1:0] susp_mode_i,
  input  logic [1:0] xtrig_i,
  output logic       start_o,
  output logic       reload_o,
  output logic       hold_o,
  output logic       park_o,
  output logic       sor_o,
  output logic       eor_o
);
  xtrig_e xt;
  susp_e  sm;
  logic   use_peer;
  logic   raw_start;
  logic   hard_stop;
  logic   soft_stop;
  logic   halted_q;

  assign xt = xtrig_e'(xtrig_i);
  assign sm = susp_e'(susp_mode_i);

  generate
    if (LOW_SIDE) begin : g_low
      assign use_peer = (xt == XT_LOW_FOLLOWS);
    end else begin : g_high
      assign use_peer = (xt == XT_HIGH_FOLLOWS);
    end
  endgenerate

  assign raw_start = use_peer ? peer_eor_i : sync_i;
  assign hard_stop = suspend_i && (sm == SUSP_HARD);
  assign soft_stop = suspend_i && (sm == SUSP_AT_SYNC);

  assign hold_o   = hard_stop || halted_q;
  assign park_o   = raw_start && soft_stop && !hold_o;
  assign start_o  = raw_start && !soft_stop && !hold_o;
  assign reload_o = trip_i && !hold_o && !start_o;

  always_ff @(posedge clk) begin
    if (rst) begin
      halted_q <= 1'b0;
      sor_o    <= 1'b0;
      eor_o    <= 1'b0;
    end else begin
      sor_o <= start_o;
      eor_o <= reload_o;
      if (!suspend_i)
        halted_q <= 1'b0;
      else if (park_o)
        halted_q <= 1'b1;
    end
  end

  // R7
  strobe_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(sor_o && eor_o));

  // R10
  halt_release_chk: assert property (@(posedge clk) disable iff (rst)
    !suspend_i |=> !halted_q);

  // R8
  peer_only_chk: assert property (@(posedge clk) disable iff (rst)
    (LOW_SIDE && xtrig_i == 2'b01 && !peer_eor_i) |=> !sor_o);
endmodule

// File: rtl/ramp_shadow_bank.sv
module ramp_shadow_bank #(
  parameter int VAL_W = 16,
  parameter int DLY_W = 13,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [VAL_W-1:0] shd_ref_i,
  input  logic [VAL_W-1:0] shd_step_i,
  input  logic [DLY_W-1:0] shd_delay_i,
  input  logic [DIV_W-1:0] shd_div_i,
  output logic [VAL_W-1:0] act_ref_o,
  output logic [VAL_W-1:0] act_step_o,
  output logic [DLY_W-1:0] act_delay_o,
  output logic [DIV_W-1:0] act_div_o
);
  always_ff @(posedge clk) begin
    if (rst) begin
      act_ref_o   <= '0;
      act_step_o  <= '0;
      act_delay_o <= '0;
      act_div_o   <= '0;
    end else if (start_i) begin
      act_ref_o   <= shd_ref_i;
      act_step_o  <= shd_step_i;
      act_delay_o <= shd_delay_i;
      act_div_o   <= shd_div_i;
    end
  end

  // R2
  shadow_copy_chk: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (act_ref_o == $past(shd_ref_i)) && (act_step_o == $past(shd_step_i)));

  // R2
  active_keep_chk: assert property (@(posedge clk) disable iff (rst)
    !start_i |=> $stable(act_step_o) && $stable(act_div_o));
endmodule

// File: rtl/ramp_stepper.sv
module ramp_stepper
  import ramp_ref_pkg::*;
#(
  parameter int VAL_W = 16,
  parameter int DLY_W = 13,
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             reload_i,
  input  logic             hold_i,
  input  logic             park_i,
  input  logic             dir_up_i,
  input  logic             load_shd_i,
  input  logic [VAL_W-1:0] shd_ref_i,
  input  logic [DLY_W-1:0] shd_delay_i,
  input  logic [VAL_W-1:0] act_ref_i,
  input  logic [VAL_W-1:0] act_step_i,
  input  logic [DIV_W-1:0] act_div_i,
  output logic [VAL_W-1:0] ramp_o
);
  rstate_e          state_q;
  logic [DLY_W-1:0] dly_q;
  logic [DIV_W-1:0] div_q;
  logic [VAL_W-1:0] ramp_q;
  logic [VAL_W:0]   sum_up;
  logic [VAL_W-1:0] next_val;

  assign sum_up = {1'b0, ramp_q} + {1'b0, act_step_i};

  always_comb begin
    if (dir_up_i)
      next_val = sum_up[VAL_W] ? {VAL_W{1'b1}} : sum_up[VAL_W-1:0];
    else
      next_val = (ramp_q < act_step_i) ? '0 : (ramp_q - act_step_i);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= RS_IDLE;
      dly_q   <= '0;
      div_q   <= '0;
      ramp_q  <= '0;
    end else if (!hold_i) begin
      if (start_i) begin
        ramp_q  <= shd_ref_i;
        dly_q   <= shd_delay_i;
        div_q   <= '0;
        state_q <= RS_RUN;
      end else if (reload_i) begin
        ramp_q  <= load_shd_i ? shd_ref_i : act_ref_i;
        state_q <= RS_IDLE;
      end else if (park_i) begin
        state_q <= RS_IDLE;
      end else if (state_q == RS_RUN) begin
        if (dly_q != '0) begin
          dly_q <= dly_q - 1'b1;
        end else if (div_q == act_div_i) begin
          ramp_q <= next_val;
          div_q  <= '0;
        end else begin
          div_q <= div_q + 1'b1;
        end
      end
    end
  end

  assign ramp_o = ramp_q;

  // R9
  freeze_hold_chk: assert property (@(posedge clk) disable iff (rst)
    hold_i |=> $stable(ramp_q));

  // R5
  down_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !reload_i && !dir_up_i) |=> (ramp_q <= $past(ramp_q)));

  // R5
  up_no_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    (!start_i && !reload_i && dir_up_i) |=> (ramp_q >= $past(ramp_q)));
endmodule

// File: rtl/ramp_dac_sel.sv
module ramp_dac_sel #(
  parameter int VAL_W = 16,
  parameter int DAC_W = 12
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             from_ramp_i,
  input  logic             on_sync_i,
  input  logic             sync_i,
  input  logic [DAC_W-1:0] shd_dac_i,
  input  logic [VAL_W-1:0] ramp_i,
  output logic [DAC_W-1:0] dac_o
);
  localparam int LSB = VAL_W - DAC_W;

  always_ff @(posedge clk) begin
    if (rst)
      dac_o <= '0;
    else if (from_ramp_i)
      dac_o <= ramp_i[VAL_W-1:LSB];
    else if (!on_sync_i || sync_i)
      dac_o <= shd_dac_i;
  end

  // R12
  dac_ramp_chk: assert property (@(posedge clk) disable iff (rst)
    from_ramp_i |=> (dac_o == $past(ramp_i[VAL_W-1:LSB])));

  // R13
  dac_static_chk: assert property (@(posedge clk) disable iff (rst)
    (!from_ramp_i && on_sync_i && !sync_i) |=> $stable(dac_o));
endmodule

// File: rtl/ramp_ref_gen.sv
module ramp_ref_gen
  import ramp_ref_pkg::*;
#(
  parameter int VAL_W    = 16,
  parameter int DLY_W    = 13,
  parameter int DIV_W    = 4,
  parameter int DAC_W    = 12,
  parameter bit LOW_SIDE = 1'b1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sync_i,
  input  logic             peer_eor_i,
  input  logic             trip_i,
  input  logic             suspend_i,
  input  logic [1:0]       susp_mode_i,
  input  logic [1:0]       xtrig_i,
  input  logic             dir_up_i,
  input  logic             trip_from_shd_i,
  input  logic             dac_from_ramp_i,
  input  logic             dac_on_sync_i,
  input  logic [VAL_W-1:0] shd_ref_i,
  input  logic [VAL_W-1:0] shd_step_i,
  input  logic [DLY_W-1:0] shd_delay_i,
  input  logic [DIV_W-1:0] shd_div_i,
  input  logic [DAC_W-1:0] shd_dac_i,
  output logic [VAL_W-1:0] ramp_o,
  output logic [DAC_W-1:0] dac_o,
  output logic             sor_o,
  output logic             eor_o,
  output logic [VAL_W-1:0] act_ref_o,
  output logic [VAL_W-1:0] act_step_o,
  output logic [DLY_W-1:0] act_delay_o,
  output logic [DIV_W-1:0] act_div_o
);
  logic start_w;
  logic reload_w;
  logic hold_w;
  logic park_w;

  ramp_start_ctrl #(.LOW_SIDE(LOW_SIDE)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .sync_i     (sync_i),
    .peer_eor_i (peer_eor_i),
    .trip_i     (trip_i),
    .suspend_i  (suspend_i),
    .susp_mode_i(susp_mode_i),
    .xtrig_i    (xtrig_i),
    .start_o    (start_w),
    .reload_o   (reload_w),
    .hold_o     (hold_w),
    .park_o     (park_w),
    .sor_o      (sor_o),
    .eor_o      (eor_o)
  );

  ramp_shadow_bank #(.VAL_W(VAL_W), .DLY_W(DLY_W), .DIV_W(DIV_W)) u_bank (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_w),
    .shd_ref_i  (shd_ref_i),
    .shd_step_i (shd_step_i),
    .shd_delay_i(shd_delay_i),
    .shd_div_i  (shd_div_i),
    .act_ref_o  (act_ref_o),
    .act_step_o (act_step_o),
    .act_delay_o(act_delay_o),
    .act_div_o  (act_div_o)
  );

  ramp_stepper #(.VAL_W(VAL_W), .DLY_W(DLY_W), .DIV_W(DIV_W)) u_step (
    .clk        (clk),
    .rst        (rst),
    .start_i    (start_w),
    .reload_i   (reload_w),
    .hold_i     (hold_w),
    .park_i     (park_w),
    .dir_up_i   (dir_up_i),
    .load_shd_i (trip_from_shd_i),
    .shd_ref_i  (shd_ref_i),
    .shd_delay_i(shd_delay_i),
    .act_ref_i  (act_ref_o),
    .act_step_i (act_step_o),
    .act_div_i  (act_div_o),
    .ramp_o     (ramp_o)
  );

  ramp_dac_sel #(.VAL_W(VAL_W), .DAC_W(DAC_W)) u_dac (
    .clk        (clk),
    .rst        (rst),
    .from_ramp_i(dac_from_ramp_i),
    .on_sync_i  (dac_on_sync_i),
    .sync_i     (sync_i),
    .shd_dac_i  (shd_dac_i),
    .ramp_i     (ramp_o),
    .dac_o      (dac_o)
  );
endmodule

// File: tb/ramp_ref_gen_tb.sv
module ramp_ref_gen_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        sync_i, peer_eor_i, trip_i, suspend_i;
  logic [1:0]  susp_mode_i, xtrig_i;
  logic        dir_up_i, trip_from_shd_i, dac_from_ramp_i, dac_on_sync_i;
  logic [15:0] shd_ref_i, shd_step_i;
  logic [12:0] shd_delay_i;
  logic [3:0]  shd_div_i;
  logic [11:0] shd_dac_i;
  logic [15:0] ramp_o, act_ref_o, act_step_o;
  logic [11:0] dac_o;
  logic        sor_o, eor_o;
  logic [12:0] act_delay_o;
  logic [3:0]  act_div_o;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  ramp_ref_gen dut_i (
    .clk(clk), .rst(rst), .sync_i(sync_i), .peer_eor_i(peer_eor_i),
    .trip_i(trip_i), .suspend_i(suspend_i), .susp_mode_i(susp_mode_i),
    .xtrig_i(xtrig_i), .dir_up_i(dir_up_i), .trip_from_shd_i(trip_from_shd_i),
    .dac_from_ramp_i(dac_from_ramp_i), .dac_on_sync_i(dac_on_sync_i),
    .shd_ref_i(shd_ref_i), .shd_step_i(shd_step_i), .shd_delay_i(shd_delay_i),
    .shd_div_i(shd_div_i), .shd_dac_i(shd_dac_i), .ramp_o(ramp_o), .dac_o(dac_o),
    .sor_o(sor_o), .eor_o(eor_o), .act_ref_o(act_ref_o), .act_step_o(act_step_o),
    .act_delay_o(act_delay_o), .act_div_o(act_div_o)
  );

  task automatic chk(string req, longint act, longint exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic longint exp_ramp(longint rv, longint stp, bit up,
                                      longint d, longint dv, longint k);
    longint n;
    longint v;
    n = (k <= d) ? 0 : (k - d) / (dv + 1);
    v = up ? rv + n * stp : rv - n * stp;
    if (v > 65535) v = 65535;
    if (v < 0) v = 0;
    return v;
  endfunction

  // start a period on sync and check the copy (R2), then scramble shadows
  task automatic start_ramp(longint rv, longint stp, bit up, longint d, longint dv);
    shd_ref_i = 16'(rv); shd_step_i = 16'(stp); shd_delay_i = 13'(d);
    shd_div_i = 4'(dv); dir_up_i = up; sync_i = 1'b1;
    cyc();
    sync_i = 1'b0;
    chk("R2 ramp load", ramp_o, rv);
    chk("R2 sor", sor_o, 1);
    chk("R2 act step", act_step_o, stp);
    chk("R2 act delay/div", {act_delay_o, act_div_o}, {13'(d), 4'(dv)});
    shd_ref_i = 16'($urandom); shd_step_i = 16'($urandom);
    shd_delay_i = 13'($urandom); shd_div_i = 4'($urandom);
  endtask

  // R3 R4 R5 R12: closed-form value per cycle
  task automatic run_ramp(longint rv, longint stp, bit up, longint d, longint dv,
                          longint k0, int ncyc, bit dac_chk);
    for (int i = 1; i <= ncyc; i++) begin
      cyc();
      chk("R3/R4/R5 ramp", ramp_o, exp_ramp(rv, stp, up, d, dv, k0 + i));
      if (dac_chk)
        chk("R12 dac", dac_o, exp_ramp(rv, stp, up, d, dv, k0 + i - 1) >> 4);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; sync_i = 1'b1; peer_eor_i = 1'b1; trip_i = 1'b1;
    suspend_i = 1'b0; susp_mode_i = 2'b00; xtrig_i = 2'b00;
    dir_up_i = 1'b1; trip_from_shd_i = 1'b0; dac_from_ramp_i = 1'b0;
    dac_on_sync_i = 1'b0; shd_ref_i = 16'h1234; shd_step_i = 16'h10;
    shd_delay_i = '0; shd_div_i = '0; shd_dac_i = 12'hABC;
    cyc(); cyc();
    // R1
    chk("R1 ramp", ramp_o, 0);
    chk("R1 dac/strobes", {dac_o, sor_o, eor_o}, 0);
    chk("R1 active", {act_ref_o, act_step_o, act_delay_o, act_div_o}, 0);
    sync_i = 1'b0; peer_eor_i = 1'b0; trip_i = 1'b0;
    rst = 1'b0;
    cyc();

    // directed saturation corners (R5)
    dac_from_ramp_i = 1'b1;
    start_ramp(16'h0005, 16'h0010, 1'b0, 0, 0);
    run_ramp(16'h0005, 16'h0010, 1'b0, 0, 0, 0, 4, 1'b1);
    start_ramp(16'hFFF0, 16'h0100, 1'b1, 1, 0);
    run_ramp(16'hFFF0, 16'h0100, 1'b1, 1, 0, 0, 5, 1'b1);
    start_ramp(16'h4000, 16'h0000, 1'b0, 0, 2);
    run_ramp(16'h4000, 16'h0000, 1'b0, 0, 2, 0, 6, 1'b1);

    // constrained random periods (R3 R4 R5 R12)
    for (int it = 0; it < 24; it++) begin
      longint rv, stp, d, dv;
      bit up;
      int n;
      rv  = $urandom_range(0, 65535);
      stp = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 65535) : $urandom_range(0, 3000);
      d   = $urandom_range(0, 6);
      dv  = $urandom_range(0, 3);
      up  = 1'($urandom);
      n   = $urandom_range(8, 30);
      start_ramp(rv, stp, up, d, dv);
      run_ramp(rv, stp, up, d, dv, 0, n, 1'b1);
    end

    // R6 trip reload from active reference
    start_ramp(16'h8000, 16'h0100, 1'b0, 0, 0);
    run_ramp(16'h8000, 16'h0100, 1'b0, 0, 0, 0, 3, 1'b0);
    shd_ref_i = 16'h1111; trip_from_shd_i = 1'b0; trip_i = 1'b1;
    cyc(); trip_i = 1'b0;
    chk("R6 reload active", ramp_o, 16'h8000);
    chk("R6 eor", eor_o, 1);
    cyc(); cyc();
    chk("R6 hold after trip", ramp_o, 16'h8000);
    chk("R6 eor one cycle", eor_o, 0);
    // R6 trip reload from shadow reference
    start_ramp(16'h4000, 16'h0020, 1'b1, 0, 0);
    run_ramp(16'h4000, 16'h0020, 1'b1, 0, 0, 0, 2, 1'b0);
    shd_ref_i = 16'h2222; trip_from_shd_i = 1'b1; trip_i = 1'b1;
    cyc(); trip_i = 1'b0;
    chk("R6 reload shadow", ramp_o, 16'h2222);

    // R7 start and trip together
    shd_ref_i = 16'h3333; shd_step_i = 16'h0; sync_i = 1'b1; trip_i = 1'b1;
    cyc(); sync_i = 1'b0; trip_i = 1'b0;
    chk("R7 start wins value", ramp_o, 16'h3333);
    chk("R7 strobes", {sor_o, eor_o}, 2'b10);
    trip_from_shd_i = 1'b0; trip_i = 1'b1;
    cyc(); trip_i = 1'b0;

    // R8 cross-trigger, low-side instance, zero step
    xtrig_i = 2'b01; shd_ref_i = 16'h0AAA; shd_step_i = 16'h0;
    sync_i = 1'b1; cyc(); sync_i = 1'b0;
    chk("R8 sync ignored in 01", {sor_o, ramp_o}, {1'b0, 16'h3333});
    peer_eor_i = 1'b1; cyc(); peer_eor_i = 1'b0;
    chk("R8 peer start in 01", {sor_o, ramp_o}, {1'b1, 16'h0AAA});
    xtrig_i = 2'b00; shd_ref_i = 16'h0BBB;
    peer_eor_i = 1'b1; cyc(); peer_eor_i = 1'b0;
    chk("R8 peer ignored in 00", {sor_o, ramp_o}, {1'b0, 16'h0AAA});
    xtrig_i = 2'b10; sync_i = 1'b1; cyc(); sync_i = 1'b0;
    chk("R8 own sync in 10", {sor_o, ramp_o}, {1'b1, 16'h0BBB});
    xtrig_i = 2'b00;

    // R9 hard freeze
    start_ramp(16'h9000, 16'h0040, 1'b1, 1, 1);
    run_ramp(16'h9000, 16'h0040, 1'b1, 1, 1, 0, 4, 1'b0);
    suspend_i = 1'b1; susp_mode_i = 2'b00; sync_i = 1'b1; trip_i = 1'b1;
    for (int i = 0; i < 5; i++) begin
      cyc();
      chk("R9 frozen", {sor_o, eor_o, ramp_o}, {2'b00, 16'(exp_ramp(16'h9000, 16'h40, 1'b1, 1, 1, 4))});
    end
    chk("R9 active kept", act_ref_o, 16'h9000);
    suspend_i = 1'b0; sync_i = 1'b0; trip_i = 1'b0;
    run_ramp(16'h9000, 16'h0040, 1'b1, 1, 1, 4, 6, 1'b0);

    // R10 park at next start
    start_ramp(16'h0800, 16'h0010, 1'b1, 0, 0);
    run_ramp(16'h0800, 16'h0010, 1'b1, 0, 0, 0, 3, 1'b0);
    suspend_i = 1'b1; susp_mode_i = 2'b01;
    run_ramp(16'h0800, 16'h0010, 1'b1, 0, 0, 3, 3, 1'b0);
    shd_ref_i = 16'h5555; sync_i = 1'b1; cyc(); sync_i = 1'b0;
    chk("R10 start refused", {sor_o, ramp_o}, {1'b0, 16'h0860});
    cyc(); cyc(); sync_i = 1'b1; cyc(); sync_i = 1'b0;
    chk("R10 parked", {sor_o, ramp_o, act_ref_o}, {1'b0, 16'h0860, 16'h0800});
    suspend_i = 1'b0; cyc();
    chk("R10 still parked", ramp_o, 16'h0860);
    sync_i = 1'b1; cyc(); sync_i = 1'b0;
    chk("R10 restart", {sor_o, ramp_o}, {1'b1, 16'h5555});

    // R11 free-run mode ignores suspend
    suspend_i = 1'b1; susp_mode_i = 2'b11;
    start_ramp(16'h7000, 16'h0123, 1'b0, 2, 1);
    run_ramp(16'h7000, 16'h0123, 1'b0, 2, 1, 0, 8, 1'b0);
    susp_mode_i = 2'b10;
    start_ramp(16'h1000, 16'h0200, 1'b1, 0, 0);
    run_ramp(16'h1000, 16'h0200, 1'b1, 0, 0, 0, 4, 1'b0);
    suspend_i = 1'b0;

    // R13 static DAC source
    dac_from_ramp_i = 1'b0; dac_on_sync_i = 1'b0; shd_dac_i = 12'h123;
    cyc();
    chk("R13 copy every clock", dac_o, 12'h123);
    dac_on_sync_i = 1'b1; shd_dac_i = 12'h456;
    cyc(); cyc();
    chk("R13 waits for sync", dac_o, 12'h123);
    sync_i = 1'b1; cyc(); sync_i = 1'b0;
    chk("R13 copy on sync", dac_o, 12'h456);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule